// File: doc/BRIEF.md
# Oversampled SPI Slave Byte Port

This block is the target end of a four-wire SPI link. It runs entirely on a fast system clock. The serial clock, the active-low select and the MOSI line are brought into that clock domain through two-flop synchronizers, and their edges are found there. The serial clock must therefore run at no more than a quarter of the system clock rate.

Both clock polarities and both clock phases are supported, set by two static mode inputs. In phase 0 every byte is its own select frame: the falling edge of select loads the byte and puts its top bit on MISO before the master produces any clock edge. In phase 1 the master may keep select low across several bytes. In that mode each byte is loaded on the first clock edge of its first bit.

Software-side logic loads the next outgoing byte through a holding register with a write strobe. It collects each incoming byte from a receive register that is flagged full until a read pulse clears it. MISO comes out as a data bit plus an output-enable, which the pad ring turns into a tri-state driver.

Top module: `spi_slave_port`

## Requirements
- R1: `miso_oe` is 1 only while the synchronized select is low. Once `ss_n_in` has been high for three consecutive clock cycles, `miso_oe` is 0, and `miso_out` is 0 whenever `miso_oe` is 0.
- R2: Every transfer is 8 bits, with the most significant bit first on both MOSI and MISO.
- R3: `cpol` sets the serial clock idle level (0 = idle low, 1 = idle high), and all four mode combinations transfer correctly. Serial clock transitions while select is high change neither `rx_full` nor `rx_data`.
- R4: With `cpha`=0, the falling edge of select loads the holding register into the shifter. Bit 7 of that byte then appears on `miso_out` before the first serial clock edge.
- R5: With `cpha`=0, after 8 bits have been received, further clock pulses within the same select frame are ignored: no new byte is received.
- R6: A write to the holding register (`tx_wr`) during a byte does not change the bits still to be shifted in that byte. The written value is sent in the next byte.
- R7: With `cpha`=1, select may stay low across several bytes. MISO changes on the first edge of each bit and MOSI is sampled on the second edge, and each new byte reloads from the holding register.
- R8: After the eighth sampling edge, the received byte is copied to `rx_data` and `rx_full` is set. An `rx_rd` pulse clears `rx_full`, and `rx_data` changes only when a byte completes.
- R9: If select rises before 8 bits have been received, the partial byte is discarded and `rx_full` and `rx_data` are unchanged. The next frame starts again from bit 7.
- R10: After reset, `miso_oe`=0, `rx_full`=0 and `rx_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase: 0 = sample on first edge, 1 = sample on second edge |
| sclk_in | input | 1 | Serial clock from the master |
| ss_n_in | input | 1 | Active-low slave select |
| mosi_in | input | 1 | Serial data from the master |
| miso_out | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output-enable for the MISO pad |
| tx_data | input | 8 | Next byte to transmit |
| tx_wr | input | 1 | Write strobe for the holding register |
| rx_data | output | 8 | Last complete received byte |
| rx_full | output | 1 | Receive register holds an unread byte |
| rx_rd | input | 1 | Read pulse, clears `rx_full` |

## Verification
A wrong bit counter or a wrong shifter state shows up at once in the byte the master collects from MISO: one bit position slips, or the byte is stale, within the frame where the fault happens. A sequencer that leaves its hold or idle state at the wrong time shows up one frame later. In that case `rx_full` rises for clocks that should have been ignored, or a partial byte reaches `rx_data`. Faults in the select path show on `miso_oe` within three system clock cycles of a select change.

// File: rtl/spi_sp_pkg.sv
package spi_sp_pkg;

  // depth of every input synchronizer; the checker timing assumes 2
  localparam int SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_HOLD = 2'd2
  } xfer_st_e;

  typedef struct packed {
    logic sample;    // capture MOSI
    logic shift;     // advance MISO
    logic sel_fall;  // select asserted
    logic sel_rise;  // select released
  } strobe_t;

endpackage

// File: rtl/spi_sp_sync.sv
module spi_sp_sync
  import spi_sp_pkg::*;
#(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [SYNC_DEPTH-1:0][W-1:0] stg_q;
  logic [SYNC_DEPTH-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[SYNC_DEPTH-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {SYNC_DEPTH{RST_VAL}};
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q = stg_q[SYNC_DEPTH-1];

endmodule

// File: rtl/spi_sp_edge.sv
module spi_sp_edge
  import spi_sp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cpol,
  input  logic    cpha,
  input  logic    sclk_s,
  input  logic    ss_n_s,
  output strobe_t stb
);

  logic sclk_q;
  logic ss_q;
  logic lvl_now;
  logic lvl_old;
  logic lead_e;
  logic trail_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      ss_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      ss_q   <= ss_n_s;
    end
  end

  always_comb begin
    // normalise to "active level" so both polarities share one detector
    lvl_now = sclk_s ^ cpol;
    lvl_old = sclk_q ^ cpol;
    lead_e  = lvl_now & ~lvl_old;
    trail_e = ~lvl_now & lvl_old;

    stb.sample   = cpha ? trail_e : lead_e;
    stb.shift    = cpha ? lead_e  : trail_e;
    stb.sel_fall = ss_q & ~ss_n_s;
    stb.sel_rise = ~ss_q & ss_n_s;
  end

endmodule

// File: rtl/spi_sp_core.sv
module spi_sp_core
  import spi_sp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpha,
  input  strobe_t           stb,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_wr,
  input  logic              rx_rd,
  output logic              shift_msb,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  xfer_st_e          st_q,   st_d;
  logic [CNT_W-1:0]  cnt_q,  cnt_d;
  logic [DATA_W-1:0] tsh_q,  tsh_d;
  logic [DATA_W-1:0] rsh_q,  rsh_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic [DATA_W-1:0] rxd_q,  rxd_d;
  logic              full_q, full_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    tsh_d  = tsh_q;
    rsh_d  = rsh_q;
    hold_d = hold_q;
    rxd_d  = rxd_q;
    full_d = full_q;

    if (tx_wr) begin
      hold_d = tx_data;
    end
    if (rx_rd) begin
      full_d = 1'b0;
    end

    unique case (st_q)
      ST_IDLE: begin
        if (stb.sel_fall) begin
          st_d  = ST_XFER;
          cnt_d = '0;
          // phase 0: top bit must be visible before the first clock edge
          if (!cpha) begin
            tsh_d = hold_q;
          end
        end
      end
      ST_XFER: begin
        if (stb.sel_rise) begin
          // partial byte is dropped
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else begin
          if (stb.shift) begin
            if (cpha && (cnt_q == '0)) begin
              tsh_d = hold_q;
            end else begin
              tsh_d = {tsh_q[DATA_W-2:0], 1'b0};
            end
          end
          if (stb.sample) begin
            rsh_d = {rsh_q[DATA_W-2:0], mosi_s};
            if (cnt_q == LAST_BIT) begin
              rxd_d  = rsh_d;
              full_d = 1'b1;
              cnt_d  = '0;
              if (!cpha) begin
                st_d = ST_HOLD;
              end
            end else begin
              cnt_d = cnt_q + CNT_ONE;
            end
          end
        end
      end
      ST_HOLD: begin
        if (stb.sel_rise) begin
          st_d = ST_IDLE;
        end
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      tsh_q  <= '0;
      rsh_q  <= '0;
      hold_q <= '0;
      rxd_q  <= '0;
      full_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      tsh_q  <= tsh_d;
      rsh_q  <= rsh_d;
      hold_q <= hold_d;
      rxd_q  <= rxd_d;
      full_q <= full_d;
    end
  end

  assign shift_msb = tsh_q[DATA_W-1];
  assign rx_data   = rxd_q;
  assign rx_full   = full_q;

endmodule

// File: rtl/spi_slave_port.sv
module spi_slave_port
  import spi_sp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              sclk_in,
  input  logic              ss_n_in,
  input  logic              mosi_in,
  output logic              miso_out,
  output logic              miso_oe,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_wr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  input  logic              rx_rd
);

  localparam int LINES = 3;

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] sync_lines;
  logic             sclk_s;
  logic             ss_n_s;
  logic             mosi_s;
  logic             shift_msb;
  strobe_t          stb;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  assign raw_lines = {sclk_in, ss_n_in, mosi_in};

  spi_sp_sync #(
    .W       (LINES),
    .RST_VAL (3'b010)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (raw_lines),
    .q     (sync_lines)
  );

  assign sclk_s = sync_lines[2];
  assign ss_n_s = sync_lines[1];
  assign mosi_s = sync_lines[0];

  spi_sp_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cpol   (cpol),
    .cpha   (cpha),
    .sclk_s (sclk_s),
    .ss_n_s (ss_n_s),
    .stb    (stb)
  );

  spi_sp_core #(
    .DATA_W (DATA_W)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cpha      (cpha),
    .stb       (stb),
    .mosi_s    (mosi_s),
    .tx_data   (tx_data),
    .tx_wr     (tx_wr),
    .rx_rd     (rx_rd),
    .shift_msb (shift_msb),
    .rx_data   (rx_data),
    .rx_full   (rx_full)
  );

  assign miso_oe  = ~ss_n_s;
  assign miso_out = miso_oe & shift_msb;

endmodule

// File: rtl/spi_slave_port_chk.sv
module spi_slave_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ss_n_in,
  input logic              miso_out,
  input logic              miso_oe,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_full,
  input logic              rx_rd
);

  // R1
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n_in && $past(ss_n_in) && $past(ss_n_in, 2)) |-> !miso_oe);

  // R1
  quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |-> !miso_out);

  // R8
  clear_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full) |-> $past(rx_rd));

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_full);

  // R3
  selected_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(miso_oe));

endmodule

bind spi_slave_port spi_slave_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .ss_n_in  (ss_n_in),
  .miso_out (miso_out),
  .miso_oe  (miso_oe),
  .rx_data  (rx_data),
  .rx_full  (rx_full),
  .rx_rd    (rx_rd)
);

// File: tb/tb_spi_slave_port.sv
module tb_spi_slave_port;

  localparam int H = 8;

  logic       clk;
  logic       rst_n;
  logic       cpol;
  logic       cpha;
  logic       sclk_in;
  logic       ss_n_in;
  logic       mosi_in;
  logic       miso_out;
  logic       miso_oe;
  logic [7:0] tx_data;
  logic       tx_wr;
  logic [7:0] rx_data;
  logic       rx_full;
  logic       rx_rd;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // {cpol, cpha, tx byte, mosi byte}
  localparam logic [17:0] VEC [6] = '{
    {1'b0, 1'b0, 8'hA5, 8'h3C},
    {1'b1, 1'b0, 8'h81, 8'h7E},
    {1'b0, 1'b1, 8'h5A, 8'hC3},
    {1'b1, 1'b1, 8'hF0, 8'h0F},
    {1'b0, 1'b0, 8'h01, 8'h80},
    {1'b1, 1'b1, 8'h80, 8'h01}
  };

  spi_slave_port dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpol     (cpol),
    .cpha     (cpha),
    .sclk_in  (sclk_in),
    .ss_n_in  (ss_n_in),
    .mosi_in  (mosi_in),
    .miso_out (miso_out),
    .miso_oe  (miso_oe),
    .tx_data  (tx_data),
    .tx_wr    (tx_wr),
    .rx_data  (rx_data),
    .rx_full  (rx_full),
    .rx_rd    (rx_rd)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_tx(input logic [7:0] v);
    tx_data = v;
    tx_wr   = 1'b1;
    cyc(1);
    tx_wr   = 1'b0;
  endtask

  task automatic rd_rx();
    rx_rd = 1'b1;
    cyc(1);
    rx_rd = 1'b0;
  endtask

  task automatic set_mode(input logic pol, input logic pha);
    cpol    = pol;
    cpha    = pha;
    sclk_in = pol;
    cyc(6);
  endtask

  task automatic sel();
    ss_n_in = 1'b0;
    cyc(H);
  endtask

  task automatic desel();
    ss_n_in = 1'b1;
    cyc(H);
  endtask

  // master side: nb clock pulses, optional holding-register write after bit 3
  task automatic run_bits(input int nb, input logic [7:0] mo, input bit mid,
                          input logic [7:0] mv, output logic [7:0] mi);
    mi = '0;
    for (int i = 0; i < nb; i++) begin
      if (!cpha) begin
        mosi_in = mo[7-i];
        cyc(H);
        sclk_in   = ~cpol;
        mi[7-i]   = miso_out;
        cyc(H);
        sclk_in   = cpol;
      end else begin
        sclk_in = ~cpol;
        mosi_in = mo[7-i];
        cyc(H);
        mi[7-i] = miso_out;
        sclk_in = cpol;
        cyc(H);
      end
      if (mid && i == 3) wr_tx(mv);
    end
    cyc(H);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] mi;
    logic [7:0] mi2;
    rst_n   = 1'b0;
    cpol    = 1'b0;
    cpha    = 1'b0;
    sclk_in = 1'b0;
    ss_n_in = 1'b1;
    mosi_in = 1'b0;
    tx_data = '0;
    tx_wr   = 1'b0;
    rx_rd   = 1'b0;
    cyc(5);
    rst_n = 1'b1;
    cyc(5);

    chk("R10 oe", miso_oe, 0);
    chk("R10 full", rx_full, 0);
    chk("R10 data", rx_data, 0);

    for (int k = 0; k < 6; k++) begin
      logic [17:0] v;
      v = VEC[k];
      set_mode(v[17], v[16]);
      wr_tx(v[15:8]);
      sel();
      run_bits(8, v[7:0], 1'b0, 8'h00, mi);
      chk("R2 rx byte", rx_data, v[7:0]);
      chk("R8 full set", rx_full, 1);
      chk("R3 R2 tx byte", mi, v[15:8]);
      desel();
      chk("R1 oe released", miso_oe, 0);
      chk("R1 line quiet", miso_out, 0);
      rd_rx();
      chk("R8 full cleared", rx_full, 0);
    end

    // R3: clocks while deselected
    set_mode(1'b1, 1'b1);
    for (int j = 0; j < 16; j++) begin
      sclk_in = ~sclk_in;
      mosi_in = ~mosi_in;
      cyc(H);
    end
    chk("R3 idle clocks full", rx_full, 0);
    chk("R3 idle clocks data", rx_data, 8'h01);
    chk("R1 idle oe", miso_oe, 0);

    // R4: top bit present before any clock edge
    set_mode(1'b0, 1'b0);
    wr_tx(8'h96);
    sel();
    chk("R4 oe", miso_oe, 1);
    chk("R4 msb early", miso_out, 1);
    run_bits(8, 8'h44, 1'b0, 8'h00, mi);
    desel();
    rd_rx();
    set_mode(1'b1, 1'b0);
    wr_tx(8'h5A);
    sel();
    chk("R4 msb early zero", miso_out, 0);
    run_bits(8, 8'h45, 1'b0, 8'h00, mi);
    chk("R4 byte", mi, 8'h5A);
    desel();
    rd_rx();

    // R6: write during a byte is deferred
    set_mode(1'b0, 1'b0);
    wr_tx(8'hC3);
    sel();
    run_bits(8, 8'h11, 1'b1, 8'h7E, mi);
    chk("R6 current byte kept", mi, 8'hC3);
    desel();
    rd_rx();
    sel();
    run_bits(8, 8'h22, 1'b0, 8'h00, mi);
    chk("R6 next byte new", mi, 8'h7E);
    chk("R6 rx", rx_data, 8'h22);

    // R5: more clocks in the same phase-0 frame
    rd_rx();
    run_bits(8, 8'hFF, 1'b0, 8'h00, mi);
    chk("R5 no second byte", rx_full, 0);
    chk("R5 data kept", rx_data, 8'h22);
    desel();

    // R9: partial byte discarded
    set_mode(1'b0, 1'b1);
    wr_tx(8'h33);
    sel();
    run_bits(5, 8'hAA, 1'b0, 8'h00, mi);
    desel();
    chk("R9 full", rx_full, 0);
    chk("R9 data", rx_data, 8'h22);
    sel();
    run_bits(8, 8'h5C, 1'b0, 8'h00, mi);
    chk("R9 restart rx", rx_data, 8'h5C);
    chk("R9 restart tx", mi, 8'h33);
    desel();
    rd_rx();

    // R7: two bytes in one phase-1 frame
    set_mode(1'b1, 1'b1);
    wr_tx(8'hA1);
    sel();
    run_bits(8, 8'h0F, 1'b0, 8'h00, mi);
    chk("R7 first rx", rx_data, 8'h0F);
    rd_rx();
    wr_tx(8'hB2);
    run_bits(8, 8'hF0, 1'b0, 8'h00, mi2);
    chk("R7 second full", rx_full, 1);
    desel();
    chk("R7 first tx", mi, 8'hA1);
    chk("R7 second tx", mi2, 8'hB2);
    chk("R7 second rx", rx_data, 8'hF0);
    rd_rx();

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule